// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side master that delivers one conversion code to a serial-input digital-to-analog converter over a three-wire link made of an active-low select, a serial clock and a serial data line. A client offers a code with a valid/ready handshake. The controller then runs one framed transaction. It lowers the select line and waits out a setup interval. It then issues exactly sixteen clock pulses with the data most significant bit first. The select line stays low for a hold interval after the last pulse, and the controller waits one more hold interval with the select line high before it takes the next code.

The code is narrower than the frame (14 bits by default), so the controller places zero pad bits ahead of it. The receiver samples data on the rising clock edge. The controller therefore changes the data line only when the clock falls and keeps it steady for the whole high phase. The high phase, the low phase, the setup interval and the hold interval are each given as a count of system-clock cycles on separate inputs. All four counts are captured when a code is accepted.

Top module: `dacwr_master`

## Requirements
- R1: Out of reset and while no code is accepted, sel_n_o is 1, sclk_o is 0, sdo_o is 0, code_ready_o is 1 and done_o is 0.
- R2: Each transaction gives exactly 16 rising edges on sclk_o while sel_n_o is 0. The bits are the code zero-extended to 16 bits and sent from bit 15 down to bit 0, so the first 16 - CODE_W bits are 0.
- R3: While sel_n_o is low, sdo_o changes only in the cycle where sclk_o falls, so it is stable during every high phase. While sel_n_o is high, sdo_o is 0.
- R4: Each high phase of sclk_o lasts max(1, high_cyc_i) cycles. Each low phase between two rising edges lasts max(1, low_cyc_i) cycles.
- R5: sel_n_o falls in the cycle after acceptance, and sdo_o shows frame bit 15 from then on. The first rising edge of sclk_o comes max(1, setup_cyc_i) cycles after sel_n_o falls.
- R6: After the last high phase, sclk_o stays low and sel_n_o stays low for max(1, hold_cyc_i) cycles, with sdo_o still holding frame bit 0. sclk_o is low in the cycle where sel_n_o rises.
- R7: code_ready_o is low from the cycle after acceptance until max(1, hold_cyc_i) cycles after sel_n_o rises. In the cycle where it returns high, done_o is high for that one cycle only.
- R8: A code is accepted on a clock edge where code_valid_i and code_ready_o are both 1. Changes to code_valid_i, code_i or any count input during a transaction do not alter or abort it.
- R9: A count input of 0 acts as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_valid_i | input | 1 | A code is offered |
| code_ready_o | output | 1 | Controller can accept a code |
| code_i | input | CODE_W | Code to send |
| high_cyc_i | input | CNT_W | Serial clock high phase, in cycles |
| low_cyc_i | input | CNT_W | Serial clock low phase, in cycles |
| setup_cyc_i | input | CNT_W | Select-low to first rising edge, in cycles |
| hold_cyc_i | input | CNT_W | Post-frame hold and recovery interval, in cycles |
| sel_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data to the converter |
| done_o | output | 1 | One-cycle pulse when a transaction has completed |

## Verification
Every output is compared in every cycle of each transaction against a waveform the bench computes from the four counts and the padded code. Fixed timing is used with all-zero, all-one, alternating and walking-one codes. These separate bit order, padding and shift-position faults. A sweep of every mix of setup and hold from 0 to 2 and high and low from 0 to 3 separates faults in the phase lengths, in the interval boundaries and in the zero-as-one rule. Transactions in which valid is held with a different code and changed counts show whether a pending request can corrupt or abort a word in flight. Back-to-back transactions test acceptance in the done cycle.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_HOLD,
    PH_RECOV
  } phase_e;

  // A programmed count of zero behaves as one cycle.
  function automatic int unsigned eff_len(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // Cycles spent away from idle for one transaction of nbits clock pulses.
  function automatic int unsigned busy_len(input int unsigned s, input int unsigned h,
                                           input int unsigned l, input int unsigned d,
                                           input int unsigned nbits);
    return eff_len(s) + nbits * eff_len(h) + (nbits - 1) * eff_len(l) + 2 * eff_len(d);
  endfunction

endpackage

// File: rtl/dacwr_phase_timer.sv
module dacwr_phase_timer
  import dacwr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(eff_len(32'(len_i)) - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);

  // R9: a load of zero length ends in the next cycle
  p_zero_len_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (len_i == '0) |=> expire_o);

endmodule

// File: rtl/dacwr_frame_shifter.sv
module dacwr_frame_shifter #(
  parameter int CODE_W     = 14,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);

  localparam int PAD_W = FRAME_BITS - CODE_W;
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_in;
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      rem_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_in = {{PAD_W{1'b0}}, code_i};
    end else begin : g_nopad
      assign frame_in = code_i[FRAME_BITS-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      rem_q   <= '0;
    end else if (load_i) begin
      frame_q <= frame_in;
      rem_q   <= IDX_W'(FRAME_BITS - 1);
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
      rem_q   <= rem_q - 1'b1;
    end
  end

  assign msb_o  = frame_q[FRAME_BITS-1];
  assign last_o = (rem_q == '0);

  // R2: the frame is never shifted beyond its final bit
  p_shift_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !last_o);

endmodule

// File: rtl/dacwr_sequencer.sv
module dacwr_sequencer
  import dacwr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] high_cyc_i,
  input  logic [CNT_W-1:0] low_cyc_i,
  input  logic [CNT_W-1:0] setup_cyc_i,
  input  logic [CNT_W-1:0] hold_cyc_i,
  input  logic             expire_i,
  input  logic             last_i,
  output logic             accept_o,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             shift_o,
  output phase_e           phase_o,
  output logic             done_o
);

  typedef struct packed {
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] hold;
  } cfg_t;

  phase_e phase_q, phase_d;
  cfg_t   cfg_q;
  logic   done_q;
  logic   finish;

  assign accept_o = (phase_q == PH_IDLE) && valid_i;

  always_comb begin
    phase_d = phase_q;
    load_o  = 1'b0;
    len_o   = '0;
    shift_o = 1'b0;
    finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (valid_i) begin
          phase_d = PH_SETUP;
          load_o  = 1'b1;
          len_o   = setup_cyc_i;
        end
      end
      PH_SETUP: begin
        if (expire_i) begin
          phase_d = PH_HIGH;
          load_o  = 1'b1;
          len_o   = cfg_q.high;
        end
      end
      PH_HIGH: begin
        if (expire_i) begin
          load_o = 1'b1;
          if (last_i) begin
            phase_d = PH_HOLD;
            len_o   = cfg_q.hold;
          end else begin
            phase_d = PH_LOW;
            len_o   = cfg_q.low;
            shift_o = 1'b1;
          end
        end
      end
      PH_LOW: begin
        if (expire_i) begin
          phase_d = PH_HIGH;
          load_o  = 1'b1;
          len_o   = cfg_q.high;
        end
      end
      PH_HOLD: begin
        if (expire_i) begin
          phase_d = PH_RECOV;
          load_o  = 1'b1;
          len_o   = cfg_q.hold;
        end
      end
      PH_RECOV: begin
        if (expire_i) begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cfg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= finish;
      if (accept_o) begin
        cfg_q <= '{high: high_cyc_i, low: low_cyc_i, setup: setup_cyc_i, hold: hold_cyc_i};
      end
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  // Checker state: cycles spent away from idle in the current transaction.
  logic [31:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (phase_q == PH_IDLE) busy_cnt <= '0;
    else                       busy_cnt <= busy_cnt + 1'b1;
  end

  // R7: the busy span matches the arithmetic from the captured counts
  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_cnt == busy_len(32'(cfg_q.setup), 32'(cfg_q.high),
                                    32'(cfg_q.low), 32'(cfg_q.hold), FRAME_BITS));

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/dacwr_master.sv
module dacwr_master
  import dacwr_pkg::*;
#(
  parameter int CODE_W     = 14,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid_i,
  output logic              code_ready_o,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  high_cyc_i,
  input  logic [CNT_W-1:0]  low_cyc_i,
  input  logic [CNT_W-1:0]  setup_cyc_i,
  input  logic [CNT_W-1:0]  hold_cyc_i,
  output logic              sel_n_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              done_o
);

  localparam int RISE_W = $clog2(FRAME_BITS + 1);

  // Internal events, named for the assertions.
  logic             accept_w;
  logic             load_w;
  logic [CNT_W-1:0] len_w;
  logic             expire_w;
  logic             shift_w;
  logic             last_w;
  logic             msb_w;
  phase_e           phase_w;
  logic             selected_w;

  dacwr_sequencer #(
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (code_valid_i),
    .high_cyc_i  (high_cyc_i),
    .low_cyc_i   (low_cyc_i),
    .setup_cyc_i (setup_cyc_i),
    .hold_cyc_i  (hold_cyc_i),
    .expire_i    (expire_w),
    .last_i      (last_w),
    .accept_o    (accept_w),
    .load_o      (load_w),
    .len_o       (len_w),
    .shift_o     (shift_w),
    .phase_o     (phase_w),
    .done_o      (done_o)
  );

  dacwr_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .len_i    (len_w),
    .expire_o (expire_w)
  );

  dacwr_frame_shifter #(
    .CODE_W     (CODE_W),
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .code_i  (code_i),
    .shift_i (shift_w),
    .msb_o   (msb_w),
    .last_o  (last_w)
  );

  assign selected_w   = (phase_w == PH_SETUP) || (phase_w == PH_HIGH) ||
                        (phase_w == PH_LOW)   || (phase_w == PH_HOLD);
  assign sel_n_o      = !selected_w;
  assign sclk_o       = (phase_w == PH_HIGH);
  assign sdo_o        = selected_w && msb_w;
  assign code_ready_o = (phase_w == PH_IDLE);

  // Checker state: rising clock edges seen within one select window.
  logic              sclk_prev;
  logic [RISE_W-1:0] rise_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      rise_cnt  <= '0;
    end else begin
      sclk_prev <= sclk_o;
      if (sel_n_o)                  rise_cnt <= '0;
      else if (sclk_o && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R2: a full frame of rising edges precedes every select release
  p_frame_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n_o) |-> rise_cnt == RISE_W'(FRAME_BITS));

  // R6: clock is low before and while select rises
  p_clk_idle_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n_o) |-> !sclk_o && !$past(sclk_o));

  // R3: data steady across a high phase
  p_data_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o && $past(sclk_o) |-> $stable(sdo_o));

  // R3: no clock and no data while deselected
  p_quiet_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_o |-> !sclk_o && !sdo_o);

  // R7: no acceptance while the converter is selected
  p_busy_when_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n_o |-> !code_ready_o);

endmodule

// File: tb/dacwr_master_tb.sv
module dacwr_master_tb;

  localparam int CODE_W = 14;
  localparam int NB     = 16;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              code_valid_i = 1'b0;
  logic              code_ready_o;
  logic [CODE_W-1:0] code_i = '0;
  logic [CNT_W-1:0]  high_cyc_i = '0;
  logic [CNT_W-1:0]  low_cyc_i = '0;
  logic [CNT_W-1:0]  setup_cyc_i = '0;
  logic [CNT_W-1:0]  hold_cyc_i = '0;
  logic              sel_n_o, sclk_o, sdo_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  dacwr_master u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_valid_i (code_valid_i),
    .code_ready_o (code_ready_o),
    .code_i       (code_i),
    .high_cyc_i   (high_cyc_i),
    .low_cyc_i    (low_cyc_i),
    .setup_cyc_i  (setup_cyc_i),
    .hold_cyc_i   (hold_cyc_i),
    .sel_n_o      (sel_n_o),
    .sclk_o       (sclk_o),
    .sdo_o        (sdo_o),
    .done_o       (done_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not end, act cycles=%0d exp below 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int atl1(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Sends one code and compares every output in every cycle until done.
  task automatic run_txn(input logic [CODE_W-1:0] code, input int s, input int h,
                         input int l, input int d, input bit disturb);
    logic [NB-1:0] f;
    int S, H, L, D, clk_end, hold_end, total;
    logic es, ec, ed, er, eo;
    logic p_sel, p_clk, p_dat;
    string tag;
    bit r3_bad;
    S = atl1(s); H = atl1(h); L = atl1(l); D = atl1(d);
    f = NB'(code);
    clk_end  = S + NB * H + (NB - 1) * L;
    hold_end = clk_end + D;
    total    = hold_end + D;
    r3_bad   = 0;
    code_i = code; setup_cyc_i = CNT_W'(s); high_cyc_i = CNT_W'(h);
    low_cyc_i = CNT_W'(l); hold_cyc_i = CNT_W'(d);
    code_valid_i = 1'b1;
    p_sel = 1'b1; p_clk = 1'b0; p_dat = 1'b0;
    for (int k = 1; k <= total + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        code_valid_i = disturb;
        if (disturb) begin
          // R8: a waiting request with other code and counts
          code_i = ~code; high_cyc_i = 8'd7; low_cyc_i = 8'd5;
          setup_cyc_i = 8'd4; hold_cyc_i = 8'd6;
        end
      end
      if (k == total) code_valid_i = 1'b0;
      es = 0; ec = 0; ed = 0; er = 0; eo = 0;
      if (k <= S) begin
        ed = f[NB-1]; tag = "R5";
      end else if (k <= clk_end) begin
        int t, idx, off;
        t = k - S - 1; idx = t / (H + L); off = t % (H + L);
        if (off < H) begin ec = 1; ed = f[NB-1-idx]; end
        else ed = f[NB-2-idx];
        tag = "R2 R4";
      end else if (k <= hold_end) begin
        ed = f[0]; tag = "R6";
      end else if (k <= total) begin
        es = 1; tag = "R7";
      end else begin
        es = 1; er = 1; eo = 1; tag = "R7";
      end
      if (disturb) tag = {tag, " R8"};
      if (s == 0 || h == 0 || l == 0 || d == 0) tag = {tag, " R9"};
      checks++;
      if ({sel_n_o, sclk_o, sdo_o, code_ready_o, done_o} != {es, ec, ed, er, eo}) begin
        fails++;
        $display("FAIL %s cycle %0d code=%h: act sel/clk/dat/rdy/done=%b%b%b%b%b exp=%b%b%b%b%b",
                 tag, k, code, sel_n_o, sclk_o, sdo_o, code_ready_o, done_o,
                 es, ec, ed, er, eo);
      end
      // R3: data may only move together with a falling clock
      if (!sel_n_o && !p_sel && (sdo_o != p_dat) && !(p_clk && !sclk_o)) begin
        r3_bad = 1;
        fails++;
        $display("FAIL R3 cycle %0d: act data moved %b->%b with clk %b->%b, exp no change",
                 k, p_dat, sdo_o, p_clk, sclk_o);
      end
      p_sel = sel_n_o; p_clk = sclk_o; p_dat = sdo_o;
    end
    checks++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs, with and without clock activity
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if ({sel_n_o, sclk_o, sdo_o, code_ready_o, done_o} != 5'b10010) begin
        fails++;
        $display("FAIL R1 idle: act sel/clk/dat/rdy/done=%b%b%b%b%b exp=10010",
                 sel_n_o, sclk_o, sdo_o, code_ready_o, done_o);
      end
    end
    // R2: code patterns with fixed timing, including padding
    run_txn(14'h0000, 2, 1, 1, 1, 0);
    run_txn(14'h3FFF, 2, 1, 1, 1, 0);
    run_txn(14'h2AAA, 2, 2, 1, 1, 0);
    run_txn(14'h1555, 1, 1, 2, 2, 0);
    for (int b = 0; b < CODE_W; b++) run_txn(CODE_W'(1) << b, 2, 1, 1, 1, 0);
    // R4 R5 R6 R9: sweep over phase and interval counts
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++)
        for (int h = 0; h < 4; h++)
          for (int l = 0; l < 4; l++)
            run_txn(CODE_W'(14'h2A5C ^ (s * 64 + d * 16 + h * 4 + l)), s, h, l, d, 0);
    // R8: pending request and changed counts during a transfer
    run_txn(14'h3C0F, 1, 2, 1, 2, 1);
    run_txn(14'h0421, 3, 1, 3, 1, 1);
    // R1: back to idle afterwards
    repeat (2) @(negedge clk);
    checks++;
    if ({sel_n_o, sclk_o, sdo_o, code_ready_o, done_o} != 5'b10010) begin
      fails++;
      $display("FAIL R1 final idle: act %b%b%b%b%b exp=10010",
               sel_n_o, sclk_o, sdo_o, code_ready_o, done_o);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule